// File: doc/BRIEF.md
# I2C Clock-Phase Generator with Stretch Detection

This block produces the open-drain clock and data timing that a byte engine needs to shift bits on an I2C bus. A programmable divider sets how many system clocks each clock phase lasts. The block never drives a line high: it only pulls the line low or lets it go. After it lets the clock line go, it waits until the clock pin, passed through a synchronizer and a filter of programmable depth, reads high. Only then does it start counting the high phase. A target can therefore hold the clock low to stretch it, and the synchronizer and filter latency makes every released interval longer. This lowers the real bit rate below the divider rate at fast settings.

The data line is moved a programmable number of system clocks after the clock line is pulled low. The level it takes is the one the engine requests at that moment. While the engine does not ask for bit clocking, the clock stays released and the data line follows the engine's request with one register of delay, so the engine can sequence START and STOP conditions itself. Three single-cycle strobes tell the engine where each bit stands: clock pulled low, clock seen high, and data updated.

Top module: `scl_timing_gen`

## Requirements
- R1: Both line outputs are drive-low enables (1 = pull low, 0 = release). After reset both are 0 and all three strobes are 0.
- R2: The effective divider is `div_i`, except that 0 is treated as 1. When the effective divider is at least SYNC_STAGES+1+depth, each clock-low phase lasts exactly the effective divider in system clocks.
- R3: A clock-low phase does not end until the filtered clock input reads low. Its length is therefore max(effective divider, SYNC_STAGES+1+depth) cycles (SYNC_STAGES = 2 by default).
- R4: After the clock is released, the high count starts only once the filtered input reads high. If the pin is held low for S cycles after release, the released interval is S+SYNC_STAGES+1+depth+effective divider cycles.
- R5: From the `high_seen_o` pulse to the next assertion of `scl_drive_low_o` there are exactly effective-divider cycles.
- R6: The filter takes a new clock level only after the synchronized input has held it for `flt_depth_i` consecutive samples. A depth of 0 means no filtering. A shorter glitch on the pin while the clock is held low does not change the released interval.
- R7: `sda_drive_low_o` takes the value of `sda_low_req_i` exactly `sda_dly_i` cycles after `scl_drive_low_o` asserts (0 = in the same cycle), and `sda_upd_o` pulses in that cycle.
- R8: While stopped, the clock is released and `sda_drive_low_o` follows `sda_low_req_i` one cycle later.
- R9: Once `run_i` is cleared, the bit in progress completes its high phase and no new low phase starts.
- R10: `low_start_o` pulses exactly in the first cycle of each clock-low phase. It and `high_seen_o` never pulse together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Engine requests continuous bit clocking |
| div_i | input | 16 | Phase length in system clocks (0 acts as 1) |
| sda_dly_i | input | 8 | Clocks from clock-low to data change |
| flt_depth_i | input | 2 | Clock input filter depth (0 = off) |
| scl_pin_i | input | 1 | Raw clock pin level |
| sda_low_req_i | input | 1 | Engine's requested data level (1 = low) |
| scl_drive_low_o | output | 1 | Pull clock line low |
| sda_drive_low_o | output | 1 | Pull data line low |
| low_start_o | output | 1 | Pulse: first cycle of clock low |
| high_seen_o | output | 1 | Pulse: high count begins |
| sda_upd_o | output | 1 | Pulse: data line updated |

## Verification
With a zero data delay, the data update and the start of the clock-low phase fall on the same edge. The bench provokes this with settings where the filter latency, not the divider, sets the low length. It judges the result by a measured delay of 0 cycles and by `sda_upd_o` being seen in the same sampling as the rising clock drive. A second overlap arises when the target's stretch release and a filter glitch land inside the same wait. Here the measured released interval must match the no-glitch formula.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
   typedef enum logic [1:0] {
      PH_IDLE    = 2'd0,
      PH_LOW     = 2'd1,
      PH_WAIT_HI = 2'd2,
      PH_HIGH    = 2'd3
   } phase_e;
endpackage

// File: rtl/scl_line_filter.sv
module scl_line_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FLT_W       = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             scl_pin_i,
   input  logic [FLT_W-1:0] depth_i,
   output logic             scl_filt_o
);
   localparam logic [FLT_W-1:0] CNT_ONE = FLT_W'(1);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   sync_s;
   logic                   filt_q;
   logic [FLT_W-1:0]       fcnt_q;

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) sync_q[0] <= 1'b1;
            else         sync_q[0] <= scl_pin_i;
         end
      end else begin : g_rest
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) sync_q[s] <= 1'b1;
            else         sync_q[s] <= sync_q[s-1];
         end
      end
   end

   assign sync_s = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         filt_q <= 1'b1;
         fcnt_q <= '0;
      end else if (sync_s == filt_q) begin
         fcnt_q <= '0;
      end else if ((depth_i == '0) || (fcnt_q == (depth_i - CNT_ONE))) begin
         filt_q <= sync_s;
         fcnt_q <= '0;
      end else begin
         fcnt_q <= fcnt_q + CNT_ONE;
      end
   end

   assign scl_filt_o = (depth_i == '0) ? sync_s : filt_q;

   AST_FILT_FROM_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (filt_q != $past(filt_q)) |-> (filt_q == $past(sync_s))); // R6
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
   import scl_gen_pkg::*;
#(
   parameter int DIV_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic             scl_filt_i,
   output logic             scl_drive_low_o,
   output logic             low_start_o,
   output logic             low_start_nx_o,
   output logic             high_seen_o,
   output logic             idle_o
);
   localparam logic [DIV_W-1:0] CNT_ONE = DIV_W'(1);

   phase_e           state_q, state_d;
   logic [DIV_W-1:0] cnt_q, cnt_d;
   logic [DIV_W-1:0] div_eff;
   logic             cnt_done;
   logic             hs_d;
   logic             low_start_q, high_seen_q;

   assign div_eff  = (div_i == '0) ? CNT_ONE : div_i;
   assign cnt_done = (cnt_q >= div_eff);

   always_comb begin
      state_d        = state_q;
      cnt_d          = cnt_done ? cnt_q : cnt_q + CNT_ONE;
      low_start_nx_o = 1'b0;
      hs_d           = 1'b0;
      unique case (state_q)
         PH_IDLE: begin
            cnt_d = cnt_q;
            if (run_i) begin
               state_d        = PH_LOW;
               cnt_d          = CNT_ONE;
               low_start_nx_o = 1'b1;
            end
         end
         PH_LOW: begin
            if (cnt_done && !scl_filt_i) state_d = PH_WAIT_HI;
         end
         PH_WAIT_HI: begin
            cnt_d = cnt_q;
            if (scl_filt_i) begin
               state_d = PH_HIGH;
               cnt_d   = CNT_ONE;
               hs_d    = 1'b1;
            end
         end
         PH_HIGH: begin
            if (cnt_done) begin
               if (run_i) begin
                  state_d        = PH_LOW;
                  cnt_d          = CNT_ONE;
                  low_start_nx_o = 1'b1;
               end else begin
                  state_d = PH_IDLE;
               end
            end
         end
         default: state_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q     <= PH_IDLE;
         cnt_q       <= '0;
         low_start_q <= 1'b0;
         high_seen_q <= 1'b0;
      end else begin
         state_q     <= state_d;
         cnt_q       <= cnt_d;
         low_start_q <= low_start_nx_o;
         high_seen_q <= hs_d;
      end
   end

   assign scl_drive_low_o = (state_q == PH_LOW);
   assign low_start_o     = low_start_q;
   assign high_seen_o     = high_seen_q;
   assign idle_o          = (state_q == PH_IDLE);

   AST_LOW_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      low_start_o |-> (scl_drive_low_o && !$past(scl_drive_low_o))); // R10
   AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({low_start_o, high_seen_o})); // R10
   AST_LOW_SEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!scl_drive_low_o && $past(scl_drive_low_o)) |-> $past(!scl_filt_i)); // R3
   AST_HIGH_AFTER_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      high_seen_o |-> $past(scl_filt_i)); // R4
   AST_NO_LOW_WHEN_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (scl_drive_low_o && !$past(scl_drive_low_o)) |-> $past(run_i)); // R9
endmodule

// File: rtl/sda_delay_unit.sv
module sda_delay_unit #(
   parameter int DLY_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             low_start_nx_i,
   input  logic             idle_i,
   input  logic [DLY_W-1:0] dly_i,
   input  logic             sda_low_req_i,
   output logic             sda_drive_low_o,
   output logic             sda_upd_o
);
   localparam logic [DLY_W-1:0] DLY_ONE = DLY_W'(1);

   logic             sda_q, upd_q, pend_q;
   logic [DLY_W-1:0] dcnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sda_q  <= 1'b0;
         upd_q  <= 1'b0;
         pend_q <= 1'b0;
         dcnt_q <= '0;
      end else begin
         upd_q <= 1'b0;
         if (low_start_nx_i) begin
            if (dly_i == '0) begin
               sda_q  <= sda_low_req_i;
               upd_q  <= 1'b1;
               pend_q <= 1'b0;
            end else begin
               pend_q <= 1'b1;
               dcnt_q <= dly_i - DLY_ONE;
            end
         end else if (pend_q) begin
            if (dcnt_q == '0) begin
               sda_q  <= sda_low_req_i;
               upd_q  <= 1'b1;
               pend_q <= 1'b0;
            end else begin
               dcnt_q <= dcnt_q - DLY_ONE;
            end
         end else if (idle_i) begin
            sda_q <= sda_low_req_i;
         end
      end
   end

   assign sda_drive_low_o = sda_q;
   assign sda_upd_o       = upd_q;

   AST_SDA_MOVES_ON_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sda_q != $past(sda_q)) |-> (upd_q || $past(idle_i))); // R7
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen #(
   parameter int DIV_W       = 16,
   parameter int DLY_W       = 8,
   parameter int FLT_W       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic [DLY_W-1:0] sda_dly_i,
   input  logic [FLT_W-1:0] flt_depth_i,
   input  logic             scl_pin_i,
   input  logic             sda_low_req_i,
   output logic             scl_drive_low_o,
   output logic             sda_drive_low_o,
   output logic             low_start_o,
   output logic             high_seen_o,
   output logic             sda_upd_o
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("scl_timing_gen: SYNC_STAGES must be at least 2");
   end
   if (DIV_W < 2 || DLY_W < 1 || FLT_W < 1) begin : g_bad_width
      $error("scl_timing_gen: field widths out of range");
   end

   logic scl_filt;
   logic low_start_nx;
   logic idle;

   scl_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FLT_W      (FLT_W)
   ) u_filter (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .scl_pin_i (scl_pin_i),
      .depth_i   (flt_depth_i),
      .scl_filt_o(scl_filt)
   );

   scl_phase_fsm #(
      .DIV_W(DIV_W)
   ) u_fsm (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .run_i          (run_i),
      .div_i          (div_i),
      .scl_filt_i     (scl_filt),
      .scl_drive_low_o(scl_drive_low_o),
      .low_start_o    (low_start_o),
      .low_start_nx_o (low_start_nx),
      .high_seen_o    (high_seen_o),
      .idle_o         (idle)
   );

   sda_delay_unit #(
      .DLY_W(DLY_W)
   ) u_sda (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .low_start_nx_i (low_start_nx),
      .idle_i         (idle),
      .dly_i          (sda_dly_i),
      .sda_low_req_i  (sda_low_req_i),
      .sda_drive_low_o(sda_drive_low_o),
      .sda_upd_o      (sda_upd_o)
   );

   AST_IDLE_SCL_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!$past(run_i) && !$past(scl_drive_low_o)) |-> !scl_drive_low_o); // R8
endmodule

// File: tb/scl_timing_gen_bench.sv
module scl_timing_gen_bench;
   localparam int SYNC = 2;

   logic        clk = 1'b0, rst_n = 1'b0, run = 1'b0;
   logic        sda_req = 1'b0, hold_low = 1'b0;
   logic [15:0] div = 16'd5;
   logic [7:0]  dly = 8'd0;
   logic [1:0]  depth = 2'd0;
   logic        scl_pin;
   logic        scl_low, sda_low, low_start, high_seen, sda_upd;

   assign scl_pin = !(scl_low || hold_low);

   scl_timing_gen u_scl_timing_gen (
      .clk_i(clk), .rst_ni(rst_n), .run_i(run), .div_i(div),
      .sda_dly_i(dly), .flt_depth_i(depth), .scl_pin_i(scl_pin),
      .sda_low_req_i(sda_req), .scl_drive_low_o(scl_low),
      .sda_drive_low_o(sda_low), .low_start_o(low_start),
      .high_seen_o(high_seen), .sda_upd_o(sda_upd)
   );

   always #2 clk = ~clk;

   int vecs = 0, miss = 0;
   int exp_low[$], exp_rel[$], exp_dly[$];
   int cfg_stretch = 0, cfg_glitch = 0;
   bit rel_valid = 1'b0;
   int rise_total = 0;

   task automatic check(input string tag, input int got, input int expv);
      vecs++;
      if (got != expv) begin
         miss++;
         $display("FAIL %s: got %0d expected %0d", tag, got, expv);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
   endtask

   function automatic int eff_div();
      return (div == 16'd0) ? 1 : int'(div);
   endfunction

   function automatic int low_len();
      int e = eff_div();
      int f = SYNC + 1 + int'(depth);
      return (e > f) ? e : f;
   endfunction

   // target model: stretch, glitch and data toggling at each clock release
   initial begin
      bit dprev = 1'b0;
      forever begin
         @(negedge clk);
         if (dprev && !scl_low) begin
            sda_req = ~sda_req;
            if (cfg_stretch != 0) begin
               hold_low = 1'b1;
               if (cfg_glitch != 0) begin
                  repeat (2) @(negedge clk);
                  hold_low = 1'b0;
                  repeat (cfg_glitch) @(negedge clk);
                  hold_low = 1'b1;
                  repeat (cfg_stretch - 2 - cfg_glitch) @(negedge clk);
               end else begin
                  repeat (cfg_stretch) @(negedge clk);
               end
               hold_low = 1'b0;
            end
         end
         dprev = scl_low;
      end
   end

   // monitor: measures phases and pops expected items
   initial begin
      int lc = 0, rc = 0, sc = 0, hs = 0;
      bit prev = 1'b0, sprev = 1'b0, swait = 1'b0;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (high_seen) hs = 0; else hs++;
            if (scl_low && !prev) begin
               rise_total++;
               check("R10 low_start with first low cycle", int'(low_start), 1);
               if (rel_valid) begin
                  if (exp_rel.size() != 0)
                     check(cfg_glitch != 0 ? "R6 glitch ignored in release" : "R4 release interval",
                           rc, exp_rel.pop_front());
                  else check("R4 unexpected release", 1, 0);
                  check("R5 high count", hs, eff_div());
                  swait = 1'b1;
                  sc = 0;
               end
               lc = 1;
            end else if (scl_low) begin
               lc++;
            end
            if (!scl_low && prev) begin
               if (exp_low.size() != 0)
                  check(low_len() > eff_div() ? "R3 low waits filtered low" : "R2 low length",
                        lc, exp_low.pop_front());
               else check("R2 unexpected low", 1, 0);
               rel_valid = 1'b1;
               rc = 1;
            end else if (!scl_low) begin
               rc++;
            end
            if (swait) begin
               if (sda_low != sprev) begin
                  if (exp_dly.size() != 0) check("R7 data delay", sc, exp_dly.pop_front());
                  else check("R7 unexpected data change", 1, 0);
                  check("R7 update strobe", int'(sda_upd), 1);
                  swait = 1'b0;
               end else begin
                  sc++;
               end
            end
            sprev = sda_low;
            prev  = scl_low;
         end
      end
   end

   task automatic run_bits(input int n, input int d, input int dl, input int dep,
                           input int s, input int g);
      int start;
      div = 16'(d); dly = 8'(dl); depth = 2'(dep);
      cfg_stretch = s; cfg_glitch = g;
      for (int i = 0; i < n; i++) exp_low.push_back(low_len());
      for (int i = 0; i < n - 1; i++) begin
         exp_rel.push_back(s + SYNC + 1 + dep + eff_div());
         exp_dly.push_back(dl);
      end
      start = rise_total;
      run = 1'b1;
      wait (rise_total >= start + n);
      @(posedge clk); #1;
      run = 1'b0;
      repeat (400) @(posedge clk);
      #1;
      check("R9 bits after stop", rise_total - start, n);
      check("R9 clock released after stop", int'(scl_low), 0);
      check("R2 scoreboard drained", exp_low.size() + exp_rel.size() + exp_dly.size(), 0);
      rel_valid = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      miss++;
      $display("FAIL watchdog: got 0 expected 1 (run completed)");
      finish_run();
   end

   initial begin
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset clock drive", int'(scl_low), 0);
      check("R1 reset data drive", int'(sda_low), 0);
      check("R1 reset strobes", int'({low_start, high_seen, sda_upd}), 0);
      // R8 passthrough while stopped
      @(posedge clk); #1 sda_req = 1'b1;
      @(negedge clk);
      check("R8 not before edge", int'(sda_low), 0);
      @(negedge clk);
      check("R8 follows request", int'(sda_low), 1);
      check("R8 clock released", int'(scl_low), 0);
      @(posedge clk); #1 sda_req = 1'b0;
      @(negedge clk); @(negedge clk);
      check("R8 follows request low", int'(sda_low), 0);
      run_bits(4, 5, 2, 0, 0, 0);
      run_bits(4, 2, 0, 3, 0, 0);
      run_bits(4, 0, 0, 1, 0, 0);
      run_bits(4, 20, 7, 2, 10, 0);
      run_bits(4, 12, 11, 3, 12, 2);
      run_bits(4, 40, 39, 0, 25, 0);
      run_bits(3, 9, 3, 3, 8, 1);
      finish_run();
   end
endmodule